// File: doc/BRIEF.md
# System Control Register Bank

This block is a 4 KiB window of 32-bit control and status registers for a small microcontroller subsystem. A bus master reaches it over a simple synchronous register bus: a select, a write enable, a word address, byte strobes and write data go in, and read data plus an error flag come back combinationally in the same cycle. The bank holds a secure-debug status word, a reset-cause record with its mask, a general retention word, a boot vector, a CPU-wait word and a wake-up control word. It also has a reserved bus-wait slot, a write-only software reset request and a constant twelve-word identification window.

The secure-debug status word is read at its own offset. It can only be changed through two write-only aliases: one ORs the written bits in, the other clears every bit written as one. Writing a one to bit 9 of the software reset word makes a small state machine emit a single-cycle reset-request pulse on the clock edge after the write. The machine has two states. `RQ_IDLE` moves to `RQ_PULSE` on a qualifying write and otherwise stays. `RQ_PULSE` stays in `RQ_PULSE` if another qualifying write arrives in that cycle and otherwise returns to `RQ_IDLE`.

Two resets are used. An active-low power-on reset clears everything. An active-low system reset clears everything except the retention word, which survives it.

Top module: `sysctl_regbank`

## Requirements
- R1: After either reset the registers read as follows: status 0x00000000, reset-cause 0x00000001, reset-cause mask 0, boot vector 0x10000000, CPU-wait 0, wake-up control 0. The power-on reset also leaves retention at 0, and the reset-request output is low.
- R2: The status word reads at byte offset 0x000. A write to 0x004 ORs the written data into it. A write to 0x008 clears each bit written as 1 and leaves the other bits alone. The dbg_stat_o output always shows the status word.
- R3: The words at 0x100 (reset-cause), 0x104 (mask), 0x10C (retention), 0x110 (boot vector), 0x118 (CPU-wait) and 0x120 (wake-up control) read back the last value written. The boot vector, CPU-wait and wake-up words also drive their outputs.
- R4: A write to 0x108 with bit 9 (byte lane 1) set raises rst_req_o for exactly one cycle, starting at the clock edge after the write. A write to 0x108 without that bit set causes no pulse and no error.
- R5: Offset 0x11C reads zero without error. Writes to it are accepted without error and change nothing.
- R6: The twelve words from 0xFD0 to 0xFFC read, in address order, 0x04, 0x00, 0x00, 0x00, 0x54, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits 7:0, with zeros in bits 31:8.
- R7: Byte lane i covers data bits 8i+7:8i. A read returns zero in every lane whose strobe is low. A write stores data only from lanes whose strobe is high and stores zero in all other lanes of the target word.
- R8: These accesses are errors: a read of 0x004, 0x008 or 0x108; a write to 0x000 or to the identification window; and any access to an unmapped offset. On an error, bus_err is high in the same cycle as the access, bus_rdata is zero, and no state changes.
- R9: The system reset leaves the retention word unchanged, and the power-on reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears all state |
| sys_rst_n | input | 1 | System reset, active low, clears all state except retention |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address (byte offset divided by 4) |
| bus_be | input | 4 | Byte strobes, one per lane |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the access |
| bus_err | output | 1 | Error flag, same cycle as the access |
| rst_req_o | output | 1 | Single-cycle software reset request |
| dbg_stat_o | output | 32 | Current secure-debug status word |
| boot_vec_o | output | 32 | Current boot vector |
| cpu_wait_o | output | 32 | Current CPU-wait word |
| wake_ctrl_o | output | 32 | Current wake-up control word |

## Verification
The assertions assume that the bus inputs are known whenever bus_sel is high, that the master holds each access stable for the whole cycle, and that bus_sel is low while either reset is asserted. The properties on the reset pulse and on status-word changes compare a cycle against the access of the cycle before, so they assume each access lasts exactly one cycle. The stimulus changes inputs only on the falling clock edge and gives every access a single cycle. It lowers bus_sel before it asserts a reset and keeps it low until the reset is released.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    // Byte offsets inside the 4 KiB window
    localparam int OFS_DBG_STAT = 'h000;
    localparam int OFS_DBG_SET  = 'h004;
    localparam int OFS_DBG_CLR  = 'h008;
    localparam int OFS_SYNDROME = 'h100;
    localparam int OFS_SYN_MASK = 'h104;
    localparam int OFS_SWRESET  = 'h108;
    localparam int OFS_RETAIN   = 'h10C;
    localparam int OFS_BOOT     = 'h110;
    localparam int OFS_CPUWAIT  = 'h118;
    localparam int OFS_BUSWAIT  = 'h11C;
    localparam int OFS_WAKE     = 'h120;
    localparam int OFS_ID_BASE  = 'hFD0;
    localparam int ID_WORDS     = 12;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_DBG_STAT,
        RG_DBG_SET,
        RG_DBG_CLR,
        RG_SYNDROME,
        RG_SYN_MASK,
        RG_SWRESET,
        RG_RETAIN,
        RG_BOOT,
        RG_CPUWAIT,
        RG_BUSWAIT,
        RG_WAKE,
        RG_ID
    } region_e;

    typedef enum logic [0:0] {
        RQ_IDLE  = 1'b0,
        RQ_PULSE = 1'b1
    } rq_state_e;

    // Identification bytes, indexed by word position inside the window
    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        logic [7:0] b;
        unique case (idx)
            4'd0:    b = 8'h04;
            4'd4:    b = 8'h54;
            4'd5:    b = 8'hB8;
            4'd6:    b = 8'h0B;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int WADDR_W = 10
) (
    input  logic [WADDR_W-1:0] waddr,
    output region_e            region,
    output logic [3:0]         id_idx
);

    localparam int ID_FIRST = OFS_ID_BASE / 4;
    localparam int ID_LAST  = ID_FIRST + ID_WORDS - 1;

    int word;

    always_comb begin
        word   = int'(waddr);
        region = RG_NONE;
        id_idx = '0;
        if (word >= ID_FIRST && word <= ID_LAST) begin
            region = RG_ID;
            id_idx = 4'(word - ID_FIRST);
        end else begin
            case (word)
                OFS_DBG_STAT / 4: region = RG_DBG_STAT;
                OFS_DBG_SET  / 4: region = RG_DBG_SET;
                OFS_DBG_CLR  / 4: region = RG_DBG_CLR;
                OFS_SYNDROME / 4: region = RG_SYNDROME;
                OFS_SYN_MASK / 4: region = RG_SYN_MASK;
                OFS_SWRESET  / 4: region = RG_SWRESET;
                OFS_RETAIN   / 4: region = RG_RETAIN;
                OFS_BOOT     / 4: region = RG_BOOT;
                OFS_CPUWAIT  / 4: region = RG_CPUWAIT;
                OFS_BUSWAIT  / 4: region = RG_BUSWAIT;
                OFS_WAKE     / 4: region = RG_WAKE;
                default:          region = RG_NONE;
            endcase
        end
    end

endmodule

// File: rtl/sysctl_lanes.sv
module sysctl_lanes #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0]   be,
    output logic [LANES*8-1:0] mask
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mask[i*8 +: 8] = {8{be[i]}};
    end

endmodule

// File: rtl/sysctl_rstreq_fsm.sv
module sysctl_rstreq_fsm
    import sysctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic pulse
);

    rq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RQ_IDLE:  if (req) state_d = RQ_PULSE;
            RQ_PULSE: state_d = req ? RQ_PULSE : RQ_IDLE;
            default:  state_d = RQ_IDLE;
        endcase
    end

    always_comb begin
        pulse = (state_q == RQ_PULSE);
    end

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int          DATA_W       = 32,
    parameter int          ADDR_W       = 12,
    parameter int          REQ_BIT      = 9,
    parameter logic [31:0] SYNDROME_RST = 32'h0000_0001,
    parameter logic [31:0] BOOT_RST     = 32'h1000_0000,
    localparam int         LANES        = DATA_W / 8,
    localparam int         WADDR_W      = ADDR_W - 2
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               sys_rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [WADDR_W-1:0] bus_addr,
    input  logic [LANES-1:0]   bus_be,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_err,
    output logic               rst_req_o,
    output logic [DATA_W-1:0]  dbg_stat_o,
    output logic [DATA_W-1:0]  boot_vec_o,
    output logic [DATA_W-1:0]  cpu_wait_o,
    output logic [DATA_W-1:0]  wake_ctrl_o
);

    logic              core_rst_n;
    region_e           region;
    logic [3:0]        id_idx;
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] wdat;
    logic [DATA_W-1:0] raw;
    logic              rd_acc, wr_acc, wr_ok, req;

    logic [DATA_W-1:0] stat_q, syn_q, msk_q, ret_q, boot_q, cpuw_q, wake_q;

    assign core_rst_n = por_n & sys_rst_n;
    assign rd_acc     = bus_sel & ~bus_we;
    assign wr_acc     = bus_sel & bus_we;

    sysctl_decode #(.WADDR_W(WADDR_W)) u_decode (
        .waddr  (bus_addr),
        .region (region),
        .id_idx (id_idx)
    );

    sysctl_lanes #(.LANES(LANES)) u_lanes (
        .be   (bus_be),
        .mask (lane_mask)
    );

    // Narrow writes are zero-padded to a full word
    assign wdat = bus_wdata & lane_mask;

    // Error classification: direction not allowed or nothing mapped
    always_comb begin
        unique case (region)
            RG_NONE:                            bus_err = bus_sel;
            RG_DBG_SET, RG_DBG_CLR, RG_SWRESET: bus_err = rd_acc;
            RG_DBG_STAT, RG_ID:                 bus_err = wr_acc;
            default:                            bus_err = 1'b0;
        endcase
    end

    assign wr_ok = wr_acc & ~bus_err;

    // Read source selection
    always_comb begin
        unique case (region)
            RG_DBG_STAT: raw = stat_q;
            RG_SYNDROME: raw = syn_q;
            RG_SYN_MASK: raw = msk_q;
            RG_RETAIN:   raw = ret_q;
            RG_BOOT:     raw = boot_q;
            RG_CPUWAIT:  raw = cpuw_q;
            RG_WAKE:     raw = wake_q;
            RG_ID:       raw = DATA_W'(id_byte(id_idx));
            default:     raw = '0;
        endcase
    end

    assign bus_rdata = (rd_acc && !bus_err) ? (raw & lane_mask) : '0;

    // Registers cleared by either reset
    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) begin
            stat_q <= '0;
            syn_q  <= DATA_W'(SYNDROME_RST);
            msk_q  <= '0;
            boot_q <= DATA_W'(BOOT_RST);
            cpuw_q <= '0;
            wake_q <= '0;
        end else if (wr_ok) begin
            unique case (region)
                RG_DBG_SET:  stat_q <= stat_q | wdat;
                RG_DBG_CLR:  stat_q <= stat_q & ~wdat;
                RG_SYNDROME: syn_q  <= wdat;
                RG_SYN_MASK: msk_q  <= wdat;
                RG_BOOT:     boot_q <= wdat;
                RG_CPUWAIT:  cpuw_q <= wdat;
                RG_WAKE:     wake_q <= wdat;
                default:     ;
            endcase
        end
    end

    // Retention word: power-on reset only
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ret_q <= '0;
        end else if (wr_ok && region == RG_RETAIN) begin
            ret_q <= wdat;
        end
    end

    assign req = wr_ok && (region == RG_SWRESET) && wdat[REQ_BIT];

    sysctl_rstreq_fsm u_rstreq (
        .clk   (clk),
        .rst_n (core_rst_n),
        .req   (req),
        .pulse (rst_req_o)
    );

    assign dbg_stat_o  = stat_q;
    assign boot_vec_o  = boot_q;
    assign cpu_wait_o  = cpuw_q;
    assign wake_ctrl_o = wake_q;

endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk
    import sysctl_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 12,
    parameter int REQ_BIT = 9,
    localparam int LANES   = DATA_W / 8,
    localparam int WADDR_W = ADDR_W - 2
) (
    input logic               clk,
    input logic               por_n,
    input logic               sys_rst_n,
    input logic               bus_sel,
    input logic               bus_we,
    input logic [WADDR_W-1:0] bus_addr,
    input logic [LANES-1:0]   bus_be,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               bus_err,
    input logic               rst_req_o,
    input logic [DATA_W-1:0]  dbg_stat_o
);

    function automatic logic [DATA_W-1:0] strobe_bits(input logic [LANES-1:0] be);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{be[i]}};
        return m;
    endfunction

    logic qual_req, rd_wo, wr_clr, wr_set, wr_stat, rd_busw;

    assign qual_req = bus_sel && bus_we && (bus_addr == WADDR_W'(OFS_SWRESET / 4))
                      && bus_be[REQ_BIT / 8] && bus_wdata[REQ_BIT];
    assign rd_wo    = bus_sel && !bus_we && ((bus_addr == WADDR_W'(OFS_DBG_SET / 4)) ||
                      (bus_addr == WADDR_W'(OFS_DBG_CLR / 4)) || (bus_addr == WADDR_W'(OFS_SWRESET / 4)));
    assign wr_clr   = bus_sel && bus_we && (bus_addr == WADDR_W'(OFS_DBG_CLR / 4));
    assign wr_set   = bus_sel && bus_we && (bus_addr == WADDR_W'(OFS_DBG_SET / 4));
    assign wr_stat  = bus_sel && bus_we && (bus_addr == WADDR_W'(OFS_DBG_STAT / 4));
    assign rd_busw  = bus_sel && !bus_we && (bus_addr == WADDR_W'(OFS_BUSWAIT / 4));

    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        bus_err |-> bus_rdata == '0);  // R8

    AST_WO_READ_ERR: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        rd_wo |-> bus_err);  // R8

    AST_STAT_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        wr_stat |=> $stable(dbg_stat_o));  // R8

    AST_REQ_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        qual_req |=> rst_req_o);  // R4

    AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        rst_req_o |-> $past(qual_req));  // R4

    AST_SET_KEEPS_BITS: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        wr_set |=> (($past(dbg_stat_o) & ~dbg_stat_o) == '0));  // R2

    AST_CLR_DROPS_BITS: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        wr_clr |=> ((dbg_stat_o & $past(bus_wdata & strobe_bits(bus_be))) == '0));  // R2

    AST_BUSWAIT_ZERO: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        rd_busw |-> (bus_rdata == '0 && !bus_err));  // R5

endmodule

bind sysctl_regbank sysctl_regbank_chk #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .REQ_BIT (REQ_BIT)
) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .sys_rst_n  (sys_rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_err    (bus_err),
    .rst_req_o  (rst_req_o),
    .dbg_stat_o (dbg_stat_o)
);

// File: tb/test_sysctl_regbank.sv
`timescale 1ns/1ps
module test_sysctl_regbank;

    logic        clk = 1'b0;
    logic        por_n, sys_rst_n;
    logic        bus_sel, bus_we;
    logic [9:0]  bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_err, rst_req_o;
    logic [31:0] dbg_stat_o, boot_vec_o, cpu_wait_o, wake_ctrl_o;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 0;

    // Behavioural reference state
    logic [31:0] m_stat, m_syn, m_msk, m_ret, m_boot, m_cpuw, m_wake;
    bit          m_req;
    int          id_tab [12] = '{'h04, 'h00, 'h00, 'h00, 'h54, 'hB8, 'h0B, 'h00,
                                 'h0D, 'hF0, 'h05, 'hB1};

    always #10 clk = ~clk;

    sysctl_regbank i_sysctl_regbank (
        .clk         (clk),
        .por_n       (por_n),
        .sys_rst_n   (sys_rst_n),
        .bus_sel     (bus_sel),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_be      (bus_be),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_err     (bus_err),
        .rst_req_o   (rst_req_o),
        .dbg_stat_o  (dbg_stat_o),
        .boot_vec_o  (boot_vec_o),
        .cpu_wait_o  (cpu_wait_o),
        .wake_ctrl_o (wake_ctrl_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] strobes(input logic [3:0] be);
        logic [31:0] m = '0;
        for (int i = 0; i < 4; i++) if (be[i]) m[i*8 +: 8] = 8'hFF;
        return m;
    endfunction

    task automatic model_clear(input bit por);
        m_stat = '0; m_syn = 32'h1; m_msk = '0; m_boot = 32'h1000_0000;
        m_cpuw = '0; m_wake = '0; m_req = 0;
        if (por) m_ret = '0;
    endtask

    task automatic model_read(input int ofs, input bit we, output bit err, output logic [31:0] raw);
        raw = '0; err = 0;
        case (ofs)
            'h000: begin raw = m_stat; err = we; end
            'h004, 'h008, 'h108: err = !we;
            'h100: raw = m_syn;
            'h104: raw = m_msk;
            'h10C: raw = m_ret;
            'h110: raw = m_boot;
            'h118: raw = m_cpuw;
            'h11C: raw = '0;
            'h120: raw = m_wake;
            default: begin
                if (ofs >= 'hFD0 && ofs <= 'hFFC) begin
                    raw = 32'(id_tab[(ofs - 'hFD0) / 4]);
                    err = we;
                end else begin
                    err = 1;
                end
            end
        endcase
    endtask

    task automatic model_write(input int ofs, input logic [31:0] wd);
        case (ofs)
            'h004: m_stat = m_stat | wd;
            'h008: m_stat = m_stat & ~wd;
            'h100: m_syn  = wd;
            'h104: m_msk  = wd;
            'h108: m_req  = wd[9];
            'h10C: m_ret  = wd;
            'h110: m_boot = wd;
            'h118: m_cpuw = wd;
            'h120: m_wake = wd;
            default: ;
        endcase
    endtask

    task automatic compare_outputs();
        check(rst_req_o === m_req, "R4", "rst_req_o", 32'(rst_req_o), 32'(m_req));
        check(dbg_stat_o === m_stat, "R2", "dbg_stat_o", dbg_stat_o, m_stat);
        check(boot_vec_o === m_boot, "R3", "boot_vec_o", boot_vec_o, m_boot);
        check(cpu_wait_o === m_cpuw, "R3", "cpu_wait_o", cpu_wait_o, m_cpuw);
        check(wake_ctrl_o === m_wake, "R3", "wake_ctrl_o", wake_ctrl_o, m_wake);
    endtask

    task automatic access(input string tag, input bit we, input int ofs,
                          input logic [3:0] be, input logic [31:0] wd);
        bit          e_err;
        logic [31:0] raw, e_data;
        @(negedge clk);
        bus_sel = 1; bus_we = we; bus_addr = 10'(ofs >> 2); bus_be = be; bus_wdata = wd;
        #2;
        model_read(ofs, we, e_err, raw);
        e_data = (!we && !e_err) ? (raw & strobes(be)) : '0;
        check(bus_err === e_err, tag, "bus_err", 32'(bus_err), 32'(e_err));
        check(bus_rdata === e_data, tag, "bus_rdata", bus_rdata, e_data);
        compare_outputs();
        @(posedge clk);
        #1;
        m_req = 0;
        if (we && !e_err) model_write(ofs, wd & strobes(be));
    endtask

    task automatic rd(input string tag, input int ofs);
        access(tag, 0, ofs, 4'hF, '0);
    endtask

    task automatic wr(input string tag, input int ofs, input logic [31:0] wd);
        access(tag, 1, ofs, 4'hF, wd);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_sel = 0;
            #2;
            compare_outputs();
            @(posedge clk);
            #1;
            m_req = 0;
        end
    endtask

    task automatic pulse_reset(input bit por);
        @(negedge clk);
        bus_sel = 0;
        if (por) por_n = 0; else sys_rst_n = 0;
        #2;
        model_clear(por);
        compare_outputs();
        @(negedge clk);
        por_n = 1; sys_rst_n = 1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        por_n = 0; sys_rst_n = 0; bus_sel = 0; bus_we = 0;
        bus_addr = '0; bus_be = '0; bus_wdata = '0;
        model_clear(1);
        repeat (3) @(negedge clk);
        por_n = 1; sys_rst_n = 1;

        // R1: reset values
        rd("R1", 'h000); rd("R1", 'h100); rd("R1", 'h104); rd("R1", 'h10C);
        rd("R1", 'h110); rd("R1", 'h118); rd("R1", 'h120);

        // R3: read/write words with two patterns
        foreach (id_tab[k]) begin end
        wr("R3", 'h100, 32'hDEAD_BEEF); wr("R3", 'h104, 32'h1234_5678);
        wr("R3", 'h10C, 32'hA5A5_5A5A); wr("R3", 'h110, 32'h0000_0400);
        wr("R3", 'h118, 32'h0000_0003); wr("R3", 'h120, 32'hFFFF_0001);
        rd("R3", 'h100); rd("R3", 'h104); rd("R3", 'h10C);
        rd("R3", 'h110); rd("R3", 'h118); rd("R3", 'h120);
        wr("R3", 'h110, 32'h5555_AAAA); rd("R3", 'h110);

        // R2: set and clear aliases
        wr("R2", 'h004, 32'h0000_F0F0); rd("R2", 'h000);
        wr("R2", 'h004, 32'h0000_0F00); rd("R2", 'h000);
        wr("R2", 'h008, 32'h0000_00F0); rd("R2", 'h000);
        wr("R2", 'h008, 32'hFFFF_FFFF); rd("R2", 'h000);

        // R4: reset request pulse
        wr("R4", 'h108, 32'h0000_0200); idle(3);
        wr("R4", 'h108, 32'hFFFF_FDFF); idle(2);
        access("R4", 1, 'h108, 4'b0001, 32'h0000_0200); idle(2);
        wr("R4", 'h108, 32'h0000_0200); wr("R4", 'h108, 32'h0000_0200); idle(2);

        // R5: reserved bus-wait word
        wr("R5", 'h11C, 32'hFFFF_FFFF); rd("R5", 'h11C); rd("R3", 'h118);

        // R6: identification window
        for (int a = 'hFD0; a <= 'hFFC; a += 4) rd("R6", a);

        // R7: narrow accesses
        access("R7", 1, 'h110, 4'b0010, 32'hAABB_CCDD); rd("R7", 'h110);
        access("R7", 0, 'h100, 4'b0001, '0);
        access("R7", 0, 'h100, 4'b1100, '0);
        access("R7", 1, 'h004, 4'b1000, 32'h8765_4321); rd("R7", 'h000);
        access("R7", 0, 'hFE0, 4'b0010, '0);

        // R8: error accesses leave state alone
        rd("R8", 'h004); rd("R8", 'h008); rd("R8", 'h108);
        wr("R8", 'h000, 32'hFFFF_FFFF); rd("R8", 'h000);
        wr("R8", 'hFD0, 32'h0000_00FF); rd("R8", 'hFD0);
        rd("R8", 'h200); wr("R8", 'h200, 32'h1); rd("R8", 'hFCC); wr("R8", 'h124, 32'h7);
        rd("R8", 'h104);

        // R9: retention survives system reset, not power-on reset
        wr("R9", 'h10C, 32'h0BAD_F00D); wr("R9", 'h118, 32'h1);
        wr("R9", 'h004, 32'h3);
        pulse_reset(0);
        rd("R9", 'h10C); rd("R1", 'h118); rd("R1", 'h000); rd("R1", 'h100);
        pulse_reset(1);
        rd("R9", 'h10C); rd("R1", 'h110);

        idle(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule